// File: doc/BRIEF.md
# Trigger-Selected External Clock Counter

An up-counter whose advance is governed either by the internal clock or by events taken from a selectable trigger source. A 5-bit trigger code picks one of four internal trigger lines, the channel-1 edge detector (both edges), the filtered channel-1 or channel-2 input with a chosen edge polarity, or the filtered external trigger pin. A 3-bit slave-mode field selects between free counting on the internal clock and external edge counting, where each active trigger edge adds one to the count.

The three pin paths (channel 1, channel 2 and external trigger) each run through a synchronizer, a digital filter that needs a run of equal samples before it accepts a new level, and a rising/falling edge detector working in the internal clock domain. The channel-2 input is itself taken from the pin or from one of fifteen internal sources. Every active trigger edge sets a sticky flag that software clears through the configuration port.

Configuration is a simple write port: address 0 holds the counter enable and the flag-clear strobe, address 1 the mode and trigger code, address 2 the channel-2 source, filter setting, polarity and a capture prescaler field that the trigger path ignores.

Top module: `trig_ext_counter`

## Requirements
- R1: After reset the count is 0, the flag is 0 and every configuration field is 0 (counter disabled, internal clock mode); with no writes the count stays 0.
- R2: The count changes only while the enable bit (address 0, bit 0) is 1; while it is 0 the count holds whatever events occur.
- R3: With slave mode 000 (address 1, bits 2:0) and enable set, the count rises by one every clock and wraps from 0xFFFF to 0.
- R4: With slave mode 111 the count rises by one at each trigger event and never by more than one per clock; any mode other than 000 and 111 holds the count.
- R5: Trigger codes (address 1, bits 7:3) 00000 to 00011 select internal trigger line 0 to 3; a rising edge on that line counts at the first clock edge that samples it high; other lines are ignored.
- R6: Trigger code 00100 counts both edges of the filtered channel-1 level, regardless of polarity.
- R7: Trigger codes 00101 and 00110 select filtered channel 1 and channel 2 with polarity bits P (address 2, bit 8) and NP (bit 9): P=0,NP=0 rising; P=1,NP=0 falling; P=1,NP=1 both edges; P=0,NP=1 rising.
- R8: Trigger code 00111 counts rising edges of the filtered external trigger pin.
- R9: Trigger codes 01000 through 11111 produce no event: no count and no flag.
- R10: The channel-2 source select (address 2, bits 3:0) picks the channel-2 pin for 0 and internal source k-1 for value k in 1 to 15.
- R11: With filter 0, a pin level first sampled at clock edge k takes effect on the count at edge k+3, never earlier.
- R12: With filter setting N (address 2, bits 7:4), a new pin level is accepted only after N+1 consecutive samples at that level; shorter pulses produce no event.
- R13: Every trigger event sets the flag, whatever the mode or enable; writing 1 to address 0 bit 1 clears it, and an event in the same cycle as the clear leaves it set.
- R14: The capture prescaler field (address 2, bits 11:10) has no effect on trigger counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word address |
| cfg_wdata | input | SRC_W+FILT_W+4 | Configuration write data |
| ch1_pin | input | 1 | Channel-1 pin |
| ch2_pin | input | 1 | Channel-2 pin |
| ch2_int | input | 2**SRC_W-1 | Internal channel-2 sources 1 to 15 |
| itr | input | 4 | Internal trigger lines |
| etr_pin | input | 1 | External trigger pin |
| count | output | CNT_W | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, two synchronizer stages, 4-bit filter and source fields. The 16-bit width keeps the wrap from 0xFFFF to 0 within a short free-running stretch, and the 4-bit source field makes the highest internal channel-2 source reachable. Filter setting 3 puts the accept/reject boundary between 3- and 4-cycle pulses, and the synchronizer depth fixes the three-edge pin-to-count latency that the bench checks cycle by cycle.

// File: rtl/trig_ext_counter.sv
module trig_ext_counter #(
  parameter int CNT_W       = 16,
  parameter int SRC_W       = 4,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_addr,
  input  logic [SRC_W+FILT_W+3:0]   cfg_wdata,
  input  logic                      ch1_pin,
  input  logic                      ch2_pin,
  input  logic [(1<<SRC_W)-2:0]     ch2_int,
  input  logic [3:0]                itr,
  input  logic                      etr_pin,
  output logic [CNT_W-1:0]          count,
  output logic                      trig_flag
);
  localparam int FILT_LSB = SRC_W;
  localparam int P_BIT    = SRC_W + FILT_W;
  localparam int NP_BIT   = P_BIT + 1;
  localparam int PSC_LSB  = P_BIT + 2;
  localparam int NCH      = 3;

  logic              cen_q, pol_p_q, pol_np_q;
  logic [2:0]        mode_q;
  logic [4:0]        tsel_q;
  logic [SRC_W-1:0]  src_q;
  logic [FILT_W-1:0] fset_q;
  logic [3:0]        itr_d;
  logic [NCH-1:0]    raw, rise, fall;
  logic              flag_clr, evt, ch2_src;
  logic              unused_psc;

  assign flag_clr   = cfg_we && cfg_addr == 2'd0 && cfg_wdata[1];
  assign unused_psc = &cfg_wdata[PSC_LSB+1:PSC_LSB];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cen_q <= 1'b0; mode_q <= '0; tsel_q <= '0;
      src_q <= '0; fset_q <= '0; pol_p_q <= 1'b0; pol_np_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: cen_q <= cfg_wdata[0];
        2'd1: begin mode_q <= cfg_wdata[2:0]; tsel_q <= cfg_wdata[7:3]; end
        2'd2: begin
          src_q    <= cfg_wdata[SRC_W-1:0];
          fset_q   <= cfg_wdata[FILT_LSB+FILT_W-1:FILT_LSB];
          pol_p_q  <= cfg_wdata[P_BIT];
          pol_np_q <= cfg_wdata[NP_BIT];
        end
        default: ;
      endcase
    end

  assign ch2_src = {ch2_int, ch2_pin}[src_q];
  assign raw     = {etr_pin, ch2_src, ch1_pin};

  for (genvar g = 0; g < NCH; g++) begin : g_path
    logic [SYNC_STAGES-1:0] sy;
    logic [FILT_W-1:0]      run;
    logic                   f_q, f_d, s;
    assign s = sy[SYNC_STAGES-1];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sy <= '0; run <= '0; f_q <= 1'b0; f_d <= 1'b0;
      end else begin
        sy  <= {sy[SYNC_STAGES-2:0], raw[g]};
        f_d <= f_q;
        if (s != f_q) begin
          if (run == fset_q) begin f_q <= s; run <= '0; end
          else run <= run + 1'b1;
        end else run <= '0;
      end
    assign rise[g] = f_q & ~f_d;
    assign fall[g] = ~f_q & f_d;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) itr_d <= '0;
    else        itr_d <= itr;

  function automatic logic pick_edge(input logic r, input logic f, input logic p, input logic np);
    return p ? (np ? (r | f) : f) : r;
  endfunction

  always_comb begin
    evt = 1'b0;
    if (tsel_q[4:3] == 2'b00) begin
      if (!tsel_q[2]) evt = itr[tsel_q[1:0]] & ~itr_d[tsel_q[1:0]];
      else case (tsel_q[1:0])
        2'd0: evt = rise[0] | fall[0];
        2'd1: evt = pick_edge(rise[0], fall[0], pol_p_q, pol_np_q);
        2'd2: evt = pick_edge(rise[1], fall[1], pol_p_q, pol_np_q);
        default: evt = rise[2];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0; trig_flag <= 1'b0;
    end else begin
      if (evt)           trig_flag <= 1'b1;
      else if (flag_clr) trig_flag <= 1'b0;
      case (mode_q)
        3'b000:  if (cen_q)        count <= count + 1'b1;
        3'b111:  if (cen_q && evt) count <= count + 1'b1;
        default: ;
      endcase
    end
endmodule

module trig_ext_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             trig_flag,
  input logic             cen,
  input logic [2:0]       mode,
  input logic [4:0]       tsel,
  input logic             flag_clr,
  input logic             evt
);
  localparam logic [CNT_W-1:0] ONE = 1;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |=> $stable(count)); // R2
  AST_INT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && mode == 3'b000) |=> count == $past(count) + ONE); // R3
  AST_EXT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b111) |=> (count == $past(count) || count == $past(count) + ONE)); // R4
  AST_OTHER_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b000 && mode != 3'b111) |=> $stable(count)); // R4
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel[4:3] != 2'b00 && !trig_flag) |=> !trig_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !flag_clr) |=> trig_flag); // R13
  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> trig_flag); // R13
endmodule

bind trig_ext_counter trig_ext_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .trig_flag(trig_flag),
  .cen(cen_q), .mode(mode_q), .tsel(tsel_q), .flag_clr(flag_clr), .evt(evt)
);

// File: tb/sim_trig_ext_counter.sv
module sim_trig_ext_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        ch1_pin = 1'b0, ch2_pin = 1'b0, etr_pin = 1'b0;
  logic [14:0] ch2_int = '0;
  logic [3:0]  itr = '0;
  logic [15:0] count;
  logic        trig_flag;
  int n_run = 0, n_fail = 0;

  trig_ext_counter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ch1_pin(ch1_pin), .ch2_pin(ch2_pin), .ch2_int(ch2_int), .itr(itr), .etr_pin(etr_pin),
    .count(count), .trig_flag(trig_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // pol = {NP, P}
  task automatic setup(input logic [4:0] tsel, input logic [2:0] mode, input logic [3:0] src,
                       input logic [3:0] filt, input logic [1:0] pol, input logic [1:0] psc,
                       input logic en);
    wr(2'd2, {psc, pol, filt, src});
    wr(2'd1, {4'b0, tsel, mode});
    wr(2'd0, {10'b0, 1'b1, en});
    repeat (8) @(negedge clk);
  endtask

  task automatic drive(input int which, input logic v);
    if (which == 0) ch1_pin = v;
    else if (which == 1) ch2_pin = v;
    else if (which == 2) etr_pin = v;
    else if (which >= 200) itr[which-200] = v;
    else ch2_int[which-100] = v;
  endtask

  task automatic pulse(input int which, input int len);
    @(negedge clk); drive(which, 1'b1);
    repeat (len) @(negedge clk);
    drive(which, 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 count after reset", count, 0);
    chk("R1 flag after reset", trig_flag, 0);
    repeat (5) @(negedge clk);
    chk("R1 idle count stays zero", count, 0);
  endtask

  task automatic t_internal;
    logic [15:0] c0;
    setup(5'd0, 3'b000, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    repeat (10) @(negedge clk);
    chk("R3 internal clock counts", count, 16'(c0 + 16'd10));
    wr(2'd0, 12'd0);
    c0 = count;
    repeat (10) @(negedge clk);
    chk("R2 disabled holds", count, c0);
  endtask

  task automatic t_latency;
    logic [15:0] c0;
    setup(5'b00110, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    chk("R13 flag cleared by setup", trig_flag, 0);
    c0 = count;
    ch2_pin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 no count before third edge", count, c0);
    @(negedge clk);
    chk("R11 count at third edge", count, 16'(c0 + 16'd1));
    chk("R13 flag set by event", trig_flag, 1);
    ch2_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 falling ignored for rising polarity", count, 16'(c0 + 16'd1));
  endtask

  task automatic t_polarity;
    logic [15:0] c0;
    setup(5'b00101, 3'b111, 4'd0, 4'd0, 2'b01, 2'b00, 1'b1);
    c0 = count;
    @(negedge clk); ch1_pin = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 falling polarity ignores rise", count, c0);
    ch1_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 falling polarity counts fall", count, 16'(c0 + 16'd1));
    setup(5'b00101, 3'b111, 4'd0, 4'd0, 2'b11, 2'b00, 1'b1);
    c0 = count;
    pulse(0, 5);
    chk("R7 both-edge polarity", count, 16'(c0 + 16'd2));
    setup(5'b00100, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(0, 5);
    chk("R6 channel-1 edge code counts both edges", count, 16'(c0 + 16'd2));
  endtask

  task automatic t_itr;
    logic [15:0] c0;
    setup(5'b00010, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(201, 2);
    chk("R5 unselected internal trigger ignored", count, c0);
    @(negedge clk); itr[2] = 1'b1;
    @(negedge clk);
    chk("R5 selected internal trigger counts next edge", count, 16'(c0 + 16'd1));
    itr[2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 one count per rising edge", count, 16'(c0 + 16'd1));
  endtask

  task automatic t_etr;
    logic [15:0] c0;
    setup(5'b00111, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(2, 3);
    chk("R8 external trigger rising edge", count, 16'(c0 + 16'd1));
  endtask

  task automatic t_reserved;
    logic [15:0] c0;
    setup(5'b01000, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(0, 4); pulse(1, 4); pulse(2, 4); pulse(200, 2);
    chk("R9 code 01000 no count", count, c0);
    chk("R9 code 01000 no flag", trig_flag, 0);
    setup(5'b11111, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(0, 4); pulse(1, 4); pulse(2, 4); pulse(203, 2);
    chk("R9 code 11111 no count", count, c0);
    chk("R9 code 11111 no flag", trig_flag, 0);
  endtask

  task automatic t_source;
    logic [15:0] c0;
    setup(5'b00110, 3'b111, 4'd5, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(1, 4);
    chk("R10 pin ignored when internal source chosen", count, c0);
    pulse(104, 4);
    chk("R10 source 5 is internal line 4", count, 16'(c0 + 16'd1));
    setup(5'b00110, 3'b111, 4'd15, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(114, 4);
    chk("R10 source 15 is internal line 14", count, 16'(c0 + 16'd1));
  endtask

  task automatic t_filter;
    logic [15:0] c0;
    setup(5'b00110, 3'b111, 4'd0, 4'd3, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(1, 3);
    chk("R12 filter 3 rejects 3-cycle pulse", count, c0);
    pulse(1, 4);
    chk("R12 filter 3 accepts 4-cycle pulse", count, 16'(c0 + 16'd1));
    setup(5'b00110, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(1, 1);
    chk("R12 filter 0 accepts 1-cycle pulse", count, 16'(c0 + 16'd1));
  endtask

  task automatic t_flag;
    logic [15:0] c0;
    setup(5'b00000, 3'b111, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    chk("R13 flag clear before race", trig_flag, 0);
    @(negedge clk);
    itr[0] = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 12'd3;
    @(negedge clk); cfg_we = 1'b0;
    chk("R13 event beats same-cycle clear", trig_flag, 1);
    itr[0] = 1'b0;
    wr(2'd0, 12'd3);
    chk("R13 clear write clears flag", trig_flag, 0);
    wr(2'd0, 12'd0);
    c0 = count;
    pulse(200, 2);
    chk("R13 flag set while disabled", trig_flag, 1);
    chk("R2 count held while disabled", count, c0);
    setup(5'b00000, 3'b011, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    pulse(200, 2);
    chk("R4 other mode holds count", count, c0);
    chk("R13 flag set in other mode", trig_flag, 1);
  endtask

  task automatic t_prescaler;
    logic [15:0] c0;
    setup(5'b00110, 3'b111, 4'd0, 4'd0, 2'b00, 2'b11, 1'b1);
    c0 = count;
    pulse(1, 3); pulse(1, 3);
    chk("R14 prescaler field has no effect", count, 16'(c0 + 16'd2));
  endtask

  task automatic t_wrap;
    logic [15:0] c0;
    int k;
    setup(5'd0, 3'b000, 4'd0, 4'd0, 2'b00, 2'b00, 1'b1);
    c0 = count;
    k = 65535 - int'(c0);
    repeat (k) @(negedge clk);
    chk("R3 reaches 0xFFFF", count, 16'hFFFF);
    @(negedge clk);
    chk("R3 wraps to zero", count, 0);
    wr(2'd0, 12'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal();
    t_latency();
    t_polarity();
    t_itr();
    t_etr();
    t_reserved();
    t_source();
    t_filter();
    t_flag();
    t_prescaler();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule